// File: doc/BRIEF.md
# Floating-Point Exception Flag Register

This block holds the exception status of a floating-point unit. Each time an arithmetic operation retires, the datapath raises a one-cycle completion strobe together with a vector of the exception events that the operation produced. The block folds those events into five sticky flags: invalid, overflow, divide-by-zero, underflow and inexact. It also rewrites a summary flag that tells whether the most recent operation raised anything at all.

Software can rewrite the flags through a 16-bit update word. The word carries a value bit and a mask bit for every flag. Each flag is loaded with the AND of its value and mask bits, except the inexact flag, which changes only when its mask bit is set. The flags leave the block as registered outputs.

The block has three named update kinds, picked each cycle by an arbiter: UPD_IDLE (no strobe, state held), UPD_OP (completion strobe only, exception merge) and UPD_SW (update word present, software load). The transitions follow only from the inputs: UPD_SW wins whenever the write strobe is high, UPD_OP is taken when only the completion strobe is high, and UPD_IDLE otherwise.

Top module: `fsr_top`

## Requirements
- R1: After reset all six flag outputs are 0.
- R2: A completion with exception bit 0 (invalid) set sets the invalid flag.
- R3: A completion with exception bit 1 (overflow) set sets the overflow flag.
- R4: A completion with exception bit 4 (divide-by-zero) set sets the divide-by-zero flag.
- R5: A completion with exception bit 2 (underflow) or bit 3 (output denormal) set sets the underflow flag.
- R6: A completion with exception bit 5 (inexact) or bit 3 (output denormal) set sets the inexact flag.
- R7: On every completion the summary flag becomes 1 if any of exception bits 0 to 5 is set and 0 otherwise.
- R8: Exception bit 6 (input denormal) affects no flag. A completion that carries only bit 6 clears the summary flag and leaves the sticky flags unchanged.
- R9: On a software update, each flag is loaded with value AND mask: summary from bits 7 and 15, invalid from 6 and 14, overflow from 5 and 13, divide-by-zero from 4 and 12, underflow from 3 and 11.
- R10: On a software update, the inexact flag is loaded with bit 2 when mask bit 10 is set, and holds its value when bit 10 is clear.
- R11: When a software update and a completion fall in the same cycle, only the software update takes effect.
- R12: Sticky flags stay set across later completions without exceptions, and nothing changes in a cycle without either strobe, whatever the exception vector holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_done_i | input | 1 | Operation-complete strobe qualifying exc_i |
| exc_i | input | 7 | Exception events, bit positions as in R2 to R8 |
| sw_we_i | input | 1 | Software update strobe |
| sw_word_i | input | 16 | Software update word of value and mask bits |
| sum_o | output | 1 | Summary flag for the last operation |
| inv_o | output | 1 | Sticky invalid flag |
| ovf_o | output | 1 | Sticky overflow flag |
| dz_o | output | 1 | Sticky divide-by-zero flag |
| unf_o | output | 1 | Sticky underflow flag |
| inx_o | output | 1 | Sticky inexact flag |

## Verification
The bench goes after the output-denormal event, which must raise both underflow and inexact. A design that maps it to only one of them would leave the other flag clear. It also drives completions that carry only the input-denormal bit: if that bit leaked into the summary OR, the summary flag would stay high when it should drop. It drives update words with mask bit 10 clear to catch a design that zeroes inexact when the mask is clear. It drives a software update and a completion in the same cycle; a design that merged the two would leave exception flags set that the word had cleared. Random traffic with a fixed seed also tests that flags stay set over clean completions, and that the exception vector has no effect when the strobe is low.

// File: rtl/fsr_pkg.sv
package fsr_pkg;

    // Exception vector, MSB first: bit 6 .. bit 0
    typedef struct packed {
        logic in_den;   // bit 6, ignored
        logic inx;      // bit 5
        logic dz;       // bit 4
        logic oden;     // bit 3
        logic unf;      // bit 2
        logic ovf;      // bit 1
        logic inv;      // bit 0
    } exc_t;

    typedef struct packed {
        logic sum;
        logic inv;
        logic ovf;
        logic dz;
        logic unf;
        logic inx;
    } flags_t;

    typedef enum logic [1:0] {
        UPD_IDLE = 2'd0,
        UPD_OP   = 2'd1,
        UPD_SW   = 2'd2
    } upd_e;

    localparam int WORD_W  = 16;
    localparam int MASK_SH = 8;   // mask bit sits this far above its value bit

endpackage

// File: rtl/fsr_arbiter.sv
module fsr_arbiter
    import fsr_pkg::*;
(
    input  logic op_done_i,
    input  logic sw_we_i,
    output upd_e kind_o
);

    always_comb begin
        if (sw_we_i) begin
            kind_o = UPD_SW;       // software wins (R11)
        end else if (op_done_i) begin
            kind_o = UPD_OP;
        end else begin
            kind_o = UPD_IDLE;
        end
    end

    always_comb begin
        assert (!(sw_we_i && kind_o != UPD_SW))
            else $error("p_sw_priority_r11");
    end

endmodule

// File: rtl/fsr_exc_map.sv
module fsr_exc_map
    import fsr_pkg::*;
(
    input  exc_t   exc_i,
    output flags_t set_o
);

    always_comb begin
        set_o     = '0;
        set_o.inv = exc_i.inv;
        set_o.ovf = exc_i.ovf;
        set_o.dz  = exc_i.dz;
        set_o.unf = exc_i.unf | exc_i.oden;
        set_o.inx = exc_i.inx | exc_i.oden;
        // input-denormal deliberately absent (R8)
        set_o.sum = exc_i.inv | exc_i.ovf | exc_i.dz | exc_i.unf
                  | exc_i.oden | exc_i.inx;
    end

endmodule

// File: rtl/fsr_sw_decode.sv
module fsr_sw_decode
    import fsr_pkg::*;
#(
    parameter int PAIRS  = 5,   // value/mask pairs loaded unconditionally
    parameter int TOP_V  = 7,   // value bit of the first pair
    parameter int INX_V  = 2    // value bit of the inexact pair
)(
    input  logic [WORD_W-1:0] word_i,
    output logic [PAIRS-1:0]  load_o,   // sum, inv, ovf, dz, unf from MSB
    output logic              inx_en_o,
    output logic              inx_val_o
);

    localparam int INX_M = INX_V + MASK_SH;

    for (genvar k = 0; k < PAIRS; k++) begin : g_pair
        localparam int VB = TOP_V - (PAIRS - 1 - k);
        assign load_o[k] = word_i[VB] & word_i[VB + MASK_SH];
    end

    assign inx_en_o  = word_i[INX_M];
    assign inx_val_o = word_i[INX_V];

endmodule

// File: rtl/fsr_top.sv
module fsr_top
    import fsr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        op_done_i,
    input  logic [6:0]  exc_i,
    input  logic        sw_we_i,
    input  logic [15:0] sw_word_i,
    output logic        sum_o,
    output logic        inv_o,
    output logic        ovf_o,
    output logic        dz_o,
    output logic        unf_o,
    output logic        inx_o
);

    localparam int PAIRS = 5;

    upd_e             kind;
    flags_t           set_v;
    flags_t           flags_q;
    flags_t           flags_d;
    logic [PAIRS-1:0] sw_load;
    logic             sw_inx_en;
    logic             sw_inx_val;

    fsr_arbiter u_arb (
        .op_done_i (op_done_i),
        .sw_we_i   (sw_we_i),
        .kind_o    (kind)
    );

    fsr_exc_map u_map (
        .exc_i (exc_t'(exc_i)),
        .set_o (set_v)
    );

    fsr_sw_decode #(.PAIRS(PAIRS)) u_dec (
        .word_i    (sw_word_i),
        .load_o    (sw_load),
        .inx_en_o  (sw_inx_en),
        .inx_val_o (sw_inx_val)
    );

    // next-state selection per update kind
    always_comb begin
        flags_d = flags_q;
        unique case (kind)
            UPD_IDLE: flags_d = flags_q;
            UPD_OP: begin
                flags_d.sum = set_v.sum;
                flags_d.inv = flags_q.inv | set_v.inv;
                flags_d.ovf = flags_q.ovf | set_v.ovf;
                flags_d.dz  = flags_q.dz  | set_v.dz;
                flags_d.unf = flags_q.unf | set_v.unf;
                flags_d.inx = flags_q.inx | set_v.inx;
            end
            UPD_SW: begin
                flags_d.sum = sw_load[4];
                flags_d.inv = sw_load[3];
                flags_d.ovf = sw_load[2];
                flags_d.dz  = sw_load[1];
                flags_d.unf = sw_load[0];
                flags_d.inx = sw_inx_en ? sw_inx_val : flags_q.inx;
            end
            default: flags_d = flags_q;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            flags_q <= flags_d;
        end
    end

    // outputs
    always_comb begin
        sum_o = flags_q.sum;
        inv_o = flags_q.inv;
        ovf_o = flags_q.ovf;
        dz_o  = flags_q.dz;
        unf_o = flags_q.unf;
        inx_o = flags_q.inx;
    end

    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> {sum_o, inv_o, ovf_o, dz_o, unf_o, inx_o} == 6'b0);

    p_inv_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_done_i && !sw_we_i && exc_i[0]) |=> inv_o);

    p_ovf_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_done_i && !sw_we_i && exc_i[1]) |=> ovf_o);

    p_dz_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_done_i && !sw_we_i && exc_i[4]) |=> dz_o);

    p_oden_both_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_done_i && !sw_we_i && exc_i[3]) |=> (unf_o && inx_o));

    p_sum_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_done_i && !sw_we_i && exc_i[5:0] == 6'b0) |=> !sum_o);

    p_sw_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sw_we_i |=> (inv_o == $past(sw_word_i[6] & sw_word_i[14])));

    p_inx_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_we_i && !sw_word_i[10]) |=> $stable(inx_o));

    p_hold_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_we_i && !op_done_i) |=> $stable({sum_o, inv_o, ovf_o, dz_o, unf_o, inx_o}));

    p_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_we_i && inv_o) |=> inv_o);

endmodule

// File: tb/sim_fsr_top.sv
module sim_fsr_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_done = 1'b0;
    logic [6:0]  exc = '0;
    logic        sw_we = 1'b0;
    logic [15:0] word = '0;
    logic        sum_o, inv_o, ovf_o, dz_o, unf_o, inx_o;

    int n_run  = 0;
    int n_fail = 0;
    logic [5:0] model = '0;   // {sum, inv, ovf, dz, unf, inx}

    always #4 clk = ~clk;   // 125 MHz

    fsr_top u0 (
        .clk(clk), .rst_n(rst_n), .op_done_i(op_done), .exc_i(exc),
        .sw_we_i(sw_we), .sw_word_i(word),
        .sum_o(sum_o), .inv_o(inv_o), .ovf_o(ovf_o),
        .dz_o(dz_o), .unf_o(unf_o), .inx_o(inx_o)
    );

    function automatic logic [5:0] next_flags(logic [5:0] cur, logic op,
                                              logic [6:0] e, logic we,
                                              logic [15:0] w);
        logic [5:0] n;
        n = cur;
        if (we) begin
            n[5] = w[7] & w[15];
            n[4] = w[6] & w[14];
            n[3] = w[5] & w[13];
            n[2] = w[4] & w[12];
            n[1] = w[3] & w[11];
            if (w[10]) n[0] = w[2];
        end else if (op) begin
            n[5] = |e[5:0];
            n[4] = cur[4] | e[0];
            n[3] = cur[3] | e[1];
            n[2] = cur[2] | e[4];
            n[1] = cur[1] | e[2] | e[3];
            n[0] = cur[0] | e[5] | e[3];
        end
        return n;
    endfunction

    task automatic check(string tag, logic [5:0] exp);
        logic [5:0] got;
        got = {sum_o, inv_o, ovf_o, dz_o, unf_o, inx_o};
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: flags got %b expected %b", tag, got, exp);
        end
    endtask

    // drive at negedge, clock in, sample at next negedge
    task automatic step(string tag, logic op, logic [6:0] e, logic we,
                        logic [15:0] w);
        op_done = op; exc = e; sw_we = we; word = w;
        model = next_flags(model, op, e, we, w);
        @(negedge clk);
        op_done = 1'b0; sw_we = 1'b0;
        check(tag, model);
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog: run hung, got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = 32'd1234;
        void'($urandom(seed));
        repeat (2) @(negedge clk);
        check("R1 reset", 6'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", 6'b0);

        step("R2 invalid",          1, 7'b0000001, 0, 16'h0);
        step("R12 clean op keeps",  1, 7'b0000000, 0, 16'h0);
        step("R3 overflow",         1, 7'b0000010, 0, 16'h0);
        step("R4 divzero",          1, 7'b0010000, 0, 16'h0);
        step("R9 clear all",        0, 7'b0,       1, 16'hFC00);
        step("R5 underflow",        1, 7'b0000100, 0, 16'h0);
        step("R9 clear",            0, 7'b0,       1, 16'hFC00);
        step("R5 R6 out-denormal",  1, 7'b0001000, 0, 16'h0);
        step("R9 clear",            0, 7'b0,       1, 16'hFC00);
        step("R6 inexact",          1, 7'b0100000, 0, 16'h0);
        step("R8 input-denormal",   1, 7'b1000000, 0, 16'h0);
        step("R7 summary clears",   1, 7'b0000000, 0, 16'h0);
        step("R12 no strobe",       0, 7'b0111111, 0, 16'h0);
        step("R10 inexact kept",    0, 7'b0,       1, 16'hF8FC);
        step("R10 inexact cleared", 0, 7'b0,       1, 16'h0400);
        step("R9 set all",          0, 7'b0,       1, 16'hFFFF);
        step("R10 set then keep",   0, 7'b0,       1, 16'h00FF);
        step("R11 sw over op",      1, 7'b0111111, 1, 16'hFC00);

        for (int i = 0; i < 400; i++) begin
            logic op, we;
            logic [6:0] e;
            logic [15:0] w;
            op = 1'($urandom());
            we = (($urandom() % 5) == 0);
            e  = 7'($urandom());
            if (($urandom() % 3) == 0) e = '0;
            w  = 16'($urandom());
            if (we && op)      step("R11 random", op, e, we, w);
            else if (we)       step("R9 R10 random", op, e, we, w);
            else if (op)       step("R7 R12 random", op, e, we, w);
            else               step("R12 random idle", op, e, we, w);
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule